// File: doc/BRIEF.md
# Multi-polynomial LFSR security-value generator

This block produces 32-bit pseudo-random words for use as key-storage masks. Inside it, eight 32-bit Fibonacci shift registers run in parallel. Each register has its own maximal-length feedback polynomial, and all of them step on every clock cycle. Because the bank keeps moving between requests, the time between requests also changes the word that comes out.

A requester pulses the generate input. In the next cycle the block presents the XOR of the eight register states, together with a one-cycle valid pulse. A seed strobe reloads the whole bank from one 32-bit word. Each register takes that word XORed with its own salt constant, so the eight registers never start equal. A register whose result would be all zero is loaded with one instead, so no register can enter the lock-up state.

Top module: `mrng_bank`

## Requirements
- R1: While `rst` is high, every lane i takes the value it would get from loading seed 0 (see R3 and R4), and `rnd_valid` and `rnd_value` are 0.
- R2: Each clock edge without a load shifts every lane one place toward its MSB. The new bit 0 is the XOR of the lane's state bits selected by its tap mask. The masks for lanes 0 to 7 are 0x80200003, 0xC0000005, 0x80002021, 0xE0000200, 0xD0000001, 0xC2020000, 0xA3000000 and 0x80000062, where bit k-1 stands for polynomial term x^k.
- R3: A clock edge with `seed_load` high sets lane i to `seed_value` XOR salt(i), where salt(i) = 0x9E3779B9 * (i+1) modulo 2^32.
- R4: A lane whose load result would be all zero is set to 0x00000001 instead, and no lane is ever all zero.
- R5: A request is accepted when `gen_req` is high at a clock edge while `rnd_valid` is low. In the following cycle `rnd_valid` is 1 and `rnd_value` is the XOR of the eight lane states held before that edge.
- R6: `rnd_valid` stays high for exactly one cycle for each accepted request.
- R7: A `gen_req` that arrives while `rnd_valid` is high is ignored. It produces no valid pulse and does not change `rnd_value`.
- R8: `rnd_value` holds its last delivered word until the next accepted request.
- R9: When `seed_load` and an accepted request fall on the same edge, the delivered word is formed from the lane states before the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Reload every lane from the seed |
| seed_value | input | 32 | Seed word |
| gen_req | input | 1 | Request one security word |
| rnd_value | output | 32 | Delivered word |
| rnd_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
The bench keeps its own model of all eight lanes and predicts each word from the request cycle. It runs several cases:

- **Seed equal to lane 0's salt.** This drives lane 0 toward zero. A design without the zero guard would leave that lane stuck at zero, and every later word would drift from the model.
- **Request held for two cycles.** A design that does not ignore the second request would give a second valid pulse. That pulse shows up in the bench as an unexpected word.
- **Load and request on the same edge.** A design that forms the word after the load would deliver the XOR of the salts, not the prediction.
- **Varied gaps between requests.** These expose a wrong tap mask or a bank that only steps on demand.

// File: rtl/mrng_pkg.sv
package mrng_pkg;

    localparam int unsigned LANE_W   = 32;
    localparam int unsigned MAX_LANE = 8;

    typedef logic [LANE_W-1:0] lane_word_t;

    localparam lane_word_t SALT_STEP = 32'h9E3779B9;

    // Per-lane salt mixed into the seed on load.
    function automatic lane_word_t lane_salt(input int unsigned idx);
        lane_word_t mult;
        mult = lane_word_t'(idx + 1);
        return lane_word_t'(SALT_STEP * mult);
    endfunction

    // Tap masks: bit k-1 set for term x^k of a maximal-length polynomial.
    function automatic lane_word_t lane_taps(input int unsigned idx);
        case (idx % MAX_LANE)
            0:       return 32'h80200003;
            1:       return 32'hC0000005;
            2:       return 32'h80002021;
            3:       return 32'hE0000200;
            4:       return 32'hD0000001;
            5:       return 32'hC2020000;
            6:       return 32'hA3000000;
            default: return 32'h80000062;
        endcase
    endfunction

    // Seed image for one lane, steering clear of the all-zero state.
    function automatic lane_word_t lane_seeded(input lane_word_t seed, input int unsigned idx);
        lane_word_t mixed;
        mixed = seed ^ lane_salt(idx);
        return (mixed == '0) ? lane_word_t'(1) : mixed;
    endfunction

endpackage

// File: rtl/mrng_lane.sv
module mrng_lane
    import mrng_pkg::*;
#(
    parameter int unsigned LANE_IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  lane_word_t seed,
    output lane_word_t state
);

    localparam lane_word_t TAPS     = lane_taps(LANE_IDX);
    localparam lane_word_t RST_WORD = lane_seeded(lane_word_t'(0), LANE_IDX);

    typedef struct packed {
        lane_word_t sr;
    } lane_regs_t;

    lane_regs_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load) begin
            lane_d.sr = lane_seeded(seed, LANE_IDX);
        end else begin
            lane_d.sr = {lane_q.sr[LANE_W-2:0], ^(lane_q.sr & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q.sr <= RST_WORD;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign state = lane_q.sr;

endmodule

// File: rtl/mrng_mix.sv
module mrng_mix
    import mrng_pkg::*;
#(
    parameter int unsigned NUM_LANES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  lane_word_t lane_vec [NUM_LANES],
    output lane_word_t value,
    output logic       valid
);

    typedef struct packed {
        lane_word_t value;
        logic       valid;
    } mix_regs_t;

    mix_regs_t  mix_d, mix_q;
    lane_word_t folded;
    logic       accept;

    always_comb begin
        folded = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            folded = folded ^ lane_vec[i];
        end
    end

    always_comb begin
        mix_d       = mix_q;
        accept      = req && !mix_q.valid;
        mix_d.valid = accept;
        if (accept) begin
            mix_d.value = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q <= '0;
        end else begin
            mix_q <= mix_d;
        end
    end

    assign value = mix_q.value;
    assign valid = mix_q.valid;

endmodule

// File: rtl/mrng_bank.sv
module mrng_bank
    import mrng_pkg::*;
#(
    parameter int unsigned NUM_LANES = MAX_LANE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic [31:0] seed_value,
    input  logic        gen_req,
    output logic [31:0] rnd_value,
    output logic        rnd_valid
);

    lane_word_t lane_state [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        mrng_lane #(
            .LANE_IDX(g)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .load (seed_load),
            .seed (seed_value),
            .state(lane_state[g])
        );
    end

    mrng_mix #(
        .NUM_LANES(NUM_LANES)
    ) u_mix (
        .clk     (clk),
        .rst     (rst),
        .req     (gen_req),
        .lane_vec(lane_state),
        .value   (rnd_value),
        .valid   (rnd_valid)
    );

endmodule

// File: rtl/mrng_bank_chk.sv
module mrng_bank_chk
    import mrng_pkg::*;
#(
    parameter int unsigned NUM_LANES = MAX_LANE
) (
    input logic        clk,
    input logic        rst,
    input logic        seed_load,
    input logic [31:0] seed_value,
    input logic        gen_req,
    input logic [31:0] rnd_value,
    input logic        rnd_valid,
    input lane_word_t  lane_state [NUM_LANES]
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rnd_valid |=> !rnd_valid); // R6

    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        (gen_req && !rnd_valid) |=> rnd_valid); // R5

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(gen_req && !rnd_valid) |=> !rnd_valid); // R7

    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(gen_req && !rnd_valid) |=> $stable(rnd_value)); // R8

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (rst)
            lane_state[g] != '0); // R4

        AST_LANE_SHIFTS: assert property (@(posedge clk) disable iff (rst)
            !seed_load |=> lane_state[g][LANE_W-1:1] == $past(lane_state[g][LANE_W-2:0])); // R2

        AST_LANE_LOADS: assert property (@(posedge clk) disable iff (rst)
            seed_load |=> lane_state[g] == lane_seeded($past(seed_value), g)); // R3
    end

endmodule

bind mrng_bank mrng_bank_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_value(seed_value),
    .gen_req   (gen_req),
    .rnd_value (rnd_value),
    .rnd_valid (rnd_valid),
    .lane_state(lane_state)
);

// File: tb/mrng_bank_tb.sv
module mrng_bank_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NL         = 8;
    localparam logic [31:0] TB_TAPS [NL] = '{
        32'h80200003, 32'hC0000005, 32'h80002021, 32'hE0000200,
        32'hD0000001, 32'hC2020000, 32'hA3000000, 32'h80000062
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        gen_req = 1'b0;
    logic [31:0] rnd_value;
    logic        rnd_valid;

    typedef struct {
        logic [31:0] val;
        int          due;
    } exp_t;

    exp_t        exp_q [$];
    logic [31:0] model [NL];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrng_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .seed_value(seed_value),
        .gen_req   (gen_req),
        .rnd_value (rnd_value),
        .rnd_valid (rnd_valid)
    );

    function automatic logic [31:0] tb_salt(input int i);
        logic [31:0] k;
        k = 32'(i + 1);
        return 32'h9E3779B9 * k;
    endfunction

    function automatic logic [31:0] tb_seed(input logic [31:0] s, input int i);
        logic [31:0] m;
        m = s ^ tb_salt(i);
        return (m == 0) ? 32'h1 : m;
    endfunction

    function automatic logic [31:0] model_xor();
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < NL; i++) acc = acc ^ model[i];
        return acc;
    endfunction

    // Reference model of the lanes (R1, R2, R3, R4)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < NL; i++) begin
            if (rst)            model[i] <= tb_seed(32'h0, i);
            else if (seed_load) model[i] <= tb_seed(seed_value, i);
            else                model[i] <= {model[i][30:0], ^(model[i] & TB_TAPS[i])};
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops predicted words as valid pulses appear (R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (rnd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected valid", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R5 due cycle", 32'(cyc), 32'(e.due));
                    check("R5 word", rnd_value, e.val);
                end
            end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R5 missing valid", 32'h0, 32'h1);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic load_seed(input logic [31:0] s);
        seed_load  = 1'b1;
        seed_value = s;
        tick();
        seed_load  = 1'b0;
    endtask

    // Driver: one accepted request, optionally with a load on the same edge.
    task automatic request(input bit with_load, input logic [31:0] s, input string tag);
        exp_t e;
        e.val = model_xor();
        e.due = cyc + 1;
        exp_q.push_back(e);
        gen_req    = 1'b1;
        seed_load  = with_load;
        seed_value = s;
        tick();
        gen_req   = 1'b0;
        seed_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R6 valid dropped"}, 32'(rnd_valid), 32'h0);
        check({tag, " R8 value held"}, rnd_value, e.val);
        tick();
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        check("R1 valid in reset", 32'(rnd_valid), 32'h0);
        check("R1 value in reset", rnd_value, 32'h0);
        #1;
        rst = 1'b0;
        tick();

        request(1'b0, 32'h0, "R1 reset image");
        idle(5);
        request(1'b0, 32'h0, "R2 free run");

        load_seed(32'h12345678);
        request(1'b0, 32'h0, "R3 after load");
        idle(17);
        request(1'b0, 32'h0, "R3 stepped");

        // Lane 0 would load zero: seed equals its salt (R4)
        load_seed(32'h9E3779B9);
        request(1'b0, 32'h0, "R4 zero guard");
        for (int k = 0; k < 4; k++) begin
            idle(9 + k * 7);
            request(1'b0, 32'h0, "R4 guarded run");
        end

        // Load on the same edge as a request (R9)
        idle(2);
        request(1'b1, 32'hCAFEF00D, "R9 load with request");
        request(1'b0, 32'h0, "R9 after load");

        // Request held across the valid cycle (R7)
        begin
            exp_t e;
            e.val = model_xor();
            e.due = cyc + 1;
            exp_q.push_back(e);
            gen_req = 1'b1;
            tick();
            tick();
            gen_req = 1'b0;
            @(negedge clk);
            check("R7 second request ignored", 32'(rnd_valid), 32'h0);
            check("R7 value unchanged", rnd_value, e.val);
            tick();
        end

        for (int k = 0; k < 20; k++) begin
            idle((k * 5) % 11);
            request(1'b0, 32'h0, "R2 varied gap");
        end

        idle(4);
        check("R5 queue drained", 32'(exp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule